// File: doc/BRIEF.md
# TDM Audio Slot Receiver

This block turns a time-division-multiplexed serial audio stream into parallel samples. It runs on the serial bit clock. On every rising edge of that clock it samples a frame-sync (word clock) input and the serial data line. A rising edge on the word clock marks the start of a frame. The frame is split into fixed 32-clock slots, and each slot carries one 24-bit sample, most significant bit first. When the last data bit of a slot arrives, the block presents the assembled sample on a parallel bus for one cycle, together with the index of the channel it came from.

Two frame lengths can be selected:

- **Single rate:** the frame lasts 256 bit clocks and holds eight slots.
- **Dual rate:** the frame lasts 128 bit clocks and holds the first four slots.

The receiver measures the distance between successive word-clock edges against the length the selected mode requires. A mismatch sets a sticky error flag, and slot counting restarts from the new edge. Downstream logic consumes the (channel, sample, strobe) triple directly.

Top module: `tdm_slot_rx`

## Requirements
- R1: After a synchronous reset the strobe, the error flag, the sample bus and the channel index all read zero.
- R2: No sample strobe appears before the first word-clock rising edge following reset. This holds however the data line moves and even if the word clock is held high through reset.
- R3: In single-rate mode (dual_rate_i = 0) each frame yields eight samples with channel indices 0,1,...,7 in slot order. Slot k occupies bit clocks 32k to 32k+31 after the frame edge. Bit 23 of each sample is the first bit of its slot and bit 0 the 24th.
- R4: The data line is first sampled on the first bit-clock rising edge at which the word clock reads high after reading low. The strobe for slot k is high for exactly one cycle, directly after the rising edge that samples bit 0 of that slot (edge 32k+23 counted from the frame edge as edge 0).
- R5: The eight bit clocks after the 24 data bits of each slot do not affect any output sample.
- R6: In dual-rate mode (dual_rate_i = 1) a frame spans 128 bit clocks and yields four samples, with channel indices 0 to 3.
- R7: A word-clock rising edge that comes before the selected frame length has elapsed sets the error flag. The new edge then becomes slot 0, bit 23 of a new frame.
- R8: If no word-clock rising edge comes at the expected frame length, the error flag goes high after the rising edge at which that length is reached. No strobe follows until the next word-clock rising edge, which starts a new frame.
- R9: The error flag stays high until reset, whatever frames follow.
- R10: The rate input is captured only at a word-clock rising edge. Changing it within a frame does not alter that frame's slot count or its expected length.
- R11: Frames whose word-clock edges are exactly the selected length apart never set the error flag, including across a change of rate mode at a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Word clock; a rising edge marks the frame start |
| sdata_i | input | 1 | Serial audio data |
| dual_rate_i | input | 1 | 1 selects dual-rate (128-clock) framing, 0 single-rate (256-clock) |
| smp_data_o | output | 24 | Assembled sample, valid while the strobe is high |
| smp_chan_o | output | 3 | Channel index of the sample, 0 for the first slot |
| smp_valid_o | output | 1 | One-cycle strobe for a completed sample |
| frame_err_o | output | 1 | Sticky frame-length error flag |

## Verification
The bench builds the block with its default parameters: eight slots of 32 bit clocks carrying 24-bit samples. This makes full 256-clock frames, 128-clock dual-rate frames, a frame cut short after 100 clocks and one stretched to 300 clocks each cost only a few hundred cycles, so every framing path, including rate switches at boundaries and a rate toggle mid-frame, is covered in one short run. The samples include all-ones, single-bit and alternating-extreme values, which exposes bit-order and shift-length faults, and the padding bits are driven both high and in a pattern that differs from the data.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DUAL   = 1'b1
    } rate_e;

    typedef enum logic {
        TRK_HUNT   = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_e;

    // Bit clocks between two word-clock rising edges in the given mode.
    function automatic int unsigned frame_bits(input rate_e r,
                                               input int unsigned slots,
                                               input int unsigned slot_bits);
        int unsigned full;
        full = slots * slot_bits;
        return (r == RATE_DUAL) ? full / 2 : full;
    endfunction

    // Number of slots that fit in one frame of the given mode.
    function automatic int unsigned active_slots(input rate_e r,
                                                 input int unsigned slots);
        return (r == RATE_DUAL) ? slots / 2 : slots;
    endfunction

endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
    import tdm_rx_pkg::*;
#(
    parameter int unsigned N_SLOTS   = 8,
    parameter int unsigned SLOT_BITS = 32,
    parameter int unsigned POS_W     = $clog2(N_SLOTS * SLOT_BITS),
    parameter int unsigned CNT_W     = $clog2(N_SLOTS * SLOT_BITS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wclk_i,
    input  logic             dual_rate_i,
    output logic [POS_W-1:0] pos_o,
    output logic             pos_vld_o,
    output logic             lock_o,
    output rate_e            rate_o,
    output logic             err_o
);

    logic             wclk_q;
    logic             start;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] flen;
    trk_e             st_q;
    rate_e            rate_q;
    logic             err_q;

    // Frame boundary: word clock seen high now, low on the previous edge.
    assign start = wclk_i & ~wclk_q;
    assign flen  = CNT_W'(frame_bits(rate_q, N_SLOTS, SLOT_BITS));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wclk_q <= 1'b1;
            cnt_q  <= '0;
            st_q   <= TRK_HUNT;
            rate_q <= RATE_SINGLE;
            err_q  <= 1'b0;
        end else begin
            wclk_q <= wclk_i;
            if (start) begin
                if (st_q == TRK_LOCKED && cnt_q != flen) begin
                    err_q <= 1'b1;          // edge came early
                end
                st_q   <= TRK_LOCKED;
                cnt_q  <= CNT_W'(1);
                rate_q <= dual_rate_i ? RATE_DUAL : RATE_SINGLE;
            end else if (st_q == TRK_LOCKED) begin
                if (cnt_q == flen) begin
                    err_q <= 1'b1;          // edge missing: drop lock
                    st_q  <= TRK_HUNT;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Position of the bit sampled on this edge within the frame.
    assign pos_o     = start ? '0 : cnt_q[POS_W-1:0];
    assign pos_vld_o = start | ((st_q == TRK_LOCKED) && (cnt_q < flen));
    assign lock_o    = (st_q == TRK_LOCKED);
    assign rate_o    = rate_q;
    assign err_o     = err_q;

endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter #(
    parameter int unsigned N_SLOTS     = 8,
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned SAMPLE_BITS = 24,
    parameter int unsigned POS_W       = $clog2(N_SLOTS * SLOT_BITS)
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         sdata_i,
    input  logic [POS_W-1:0]             pos_i,
    input  logic                         pos_vld_i,
    output logic [SAMPLE_BITS-1:0]       data_o,
    output logic [$clog2(N_SLOTS)-1:0]   chan_o,
    output logic                         valid_o
);

    localparam int unsigned SB_W = $clog2(SLOT_BITS);
    localparam int unsigned CH_W = $clog2(N_SLOTS);
    localparam logic [SB_W:0] SMP_LIM  = (SB_W + 1)'(SAMPLE_BITS);
    localparam logic [SB_W:0] SMP_LAST = (SB_W + 1)'(SAMPLE_BITS - 1);

    typedef struct packed {
        logic [CH_W-1:0]        chan;
        logic [SAMPLE_BITS-1:0] data;
    } sample_t;

    logic [SB_W-1:0]        bit_in_slot;
    logic [CH_W-1:0]        slot_idx;
    logic [SB_W:0]          bit_ext;
    logic [SAMPLE_BITS-2:0] sh_q;
    sample_t                out_q;
    logic                   vld_q;

    assign bit_in_slot = pos_i[SB_W-1:0];
    assign slot_idx    = pos_i[SB_W +: CH_W];
    assign bit_ext     = {1'b0, bit_in_slot};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q  <= '0;
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (pos_vld_i && bit_ext < SMP_LIM) begin
                sh_q <= {sh_q[SAMPLE_BITS-3:0], sdata_i};
                if (bit_ext == SMP_LAST) begin
                    out_q.data <= {sh_q, sdata_i};
                    out_q.chan <= slot_idx;
                    vld_q      <= 1'b1;
                end
            end
        end
    end

    assign data_o  = out_q.data;
    assign chan_o  = out_q.chan;
    assign valid_o = vld_q;

endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
    import tdm_rx_pkg::*;
#(
    parameter int unsigned N_SLOTS     = 8,
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned SAMPLE_BITS = 24
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       wclk_i,
    input  logic                       sdata_i,
    input  logic                       dual_rate_i,
    output logic [SAMPLE_BITS-1:0]     smp_data_o,
    output logic [$clog2(N_SLOTS)-1:0] smp_chan_o,
    output logic                       smp_valid_o,
    output logic                       frame_err_o
);

    localparam int unsigned CH_W  = $clog2(N_SLOTS);
    localparam int unsigned POS_W = $clog2(N_SLOTS * SLOT_BITS);
    localparam int unsigned CNT_W = $clog2(N_SLOTS * SLOT_BITS + 1);

    logic [POS_W-1:0] trk_pos;
    logic             trk_pos_vld;
    logic             trk_lock;
    rate_e            trk_rate;
    logic             trk_dual;

    tdm_frame_tracker #(
        .N_SLOTS   (N_SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .POS_W     (POS_W),
        .CNT_W     (CNT_W)
    ) u_trk (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wclk_i      (wclk_i),
        .dual_rate_i (dual_rate_i),
        .pos_o       (trk_pos),
        .pos_vld_o   (trk_pos_vld),
        .lock_o      (trk_lock),
        .rate_o      (trk_rate),
        .err_o       (frame_err_o)
    );

    assign trk_dual = (trk_rate == RATE_DUAL);

    tdm_slot_shifter #(
        .N_SLOTS     (N_SLOTS),
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .POS_W       (POS_W)
    ) u_shf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sdata_i   (sdata_i),
        .pos_i     (trk_pos),
        .pos_vld_i (trk_pos_vld),
        .data_o    (smp_data_o),
        .chan_o    (smp_chan_o),
        .valid_o   (smp_valid_o)
    );

endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned CH_W    = 3
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            valid_i,
    input logic [CH_W-1:0] chan_i,
    input logic            err_i,
    input logic            lock_i,
    input logic            dual_i
);

    // R4: a strobe never lasts longer than one cycle
    p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> !valid_i);

    // R9: the error flag holds until reset
    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        err_i |=> err_i);

    // R2 / R8: no strobe follows a cycle without frame lock
    p_quiet_unlocked_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !lock_i |=> !valid_i);

    // R6: dual-rate frames only produce the lower half of the channel indices
    p_dual_chan_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && dual_i) |-> (int'(chan_i) < int'(N_SLOTS / 2)));

endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(
    .N_SLOTS (N_SLOTS),
    .CH_W    (CH_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .valid_i (smp_valid_o),
    .chan_i  (smp_chan_o),
    .err_i   (frame_err_o),
    .lock_i  (trk_lock),
    .dual_i  (trk_dual)
);

// File: tb/sim_tdm_slot_rx.sv
module sim_tdm_slot_rx;

    logic        clk = 1'b0;
    logic        rst;
    logic        wclk;
    logic        sdata;
    logic        dual_rate;
    logic [23:0] smp_data;
    logic [2:0]  smp_chan;
    logic        smp_valid;
    logic        frame_err;

    int    checks = 0;
    int    errors = 0;
    int    ncyc   = 0;
    int    nvalid = 0;
    bit    done   = 1'b0;
    string tag_r  = "R3";

    typedef struct {
        int chan;
        int data;
        int cyc;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) ncyc <= ncyc + 1;

    tdm_slot_rx u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .wclk_i      (wclk),
        .sdata_i     (sdata),
        .dual_rate_i (dual_rate),
        .smp_data_o  (smp_data),
        .smp_chan_o  (smp_chan),
        .smp_valid_o (smp_valid),
        .frame_err_o (frame_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] smp(input int seed, input int k);
        logic [31:0] h;
        if (seed == 1) return (k % 2 == 0) ? 24'hFFFFFF : 24'h000001;
        if (seed == 2) return (k % 2 == 0) ? 24'h800000 : 24'h7FFFFE;
        h = (seed * 32'h9E3779B1) ^ (k * 32'h7F4A7C15) ^ (32'(k) << (seed % 5));
        return h[23:0];
    endfunction

    // Driver: plays one frame and queues the samples the requirements predict.
    task automatic send_frame(input int len, input bit dual, input int seed,
                              input bit pad1, input int toggle_at, input int probe);
        for (int i = 0; i < len; i++) begin
            int          k;
            int          b;
            logic [23:0] s;
            @(negedge clk);
            k = i / 32;
            b = i % 32;
            s = smp(seed, k);
            wclk      = (i == 0);
            dual_rate = (toggle_at >= 0 && i >= toggle_at) ? ~dual : dual;
            sdata     = (b < 24) ? s[23 - b] : (pad1 ? 1'b1 : ~s[b % 24]);
            if (b == 23 && k < (dual ? 4 : 8))
                q.push_back('{k, int'(s), ncyc + 1});
            if (probe > 0 && i == probe)
                chk(frame_err == 1'b0, "R8", "err before length reached", frame_err, 0);
            if (probe > 0 && i == probe + 1)
                chk(frame_err == 1'b1, "R8", "err after missing edge", frame_err, 1);
        end
        chk(q.size() == 0, tag_r, "samples still pending at frame end", q.size(), 0);
        q.delete();
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin
        if (!rst && smp_valid) begin
            nvalid++;
            if (q.size() == 0) begin
                chk(1'b0, tag_r, "unexpected strobe chan", smp_chan, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(smp_chan) == e.chan, tag_r, "channel", smp_chan, e.chan);
                chk(int'(smp_data) == e.data, tag_r, "sample", smp_data, e.data);
                chk(ncyc == e.cyc, "R4", "strobe cycle", ncyc, e.cyc);
            end
        end
    end

    initial begin
        rst = 1'b1; wclk = 1'b1; sdata = 1'b0; dual_rate = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(smp_valid == 1'b0, "R1", "strobe", smp_valid, 0);
        chk(frame_err == 1'b0, "R1", "err", frame_err, 0);
        chk(smp_data == 24'h0, "R1", "data", smp_data, 0);
        chk(smp_chan == 3'd0, "R1", "chan", smp_chan, 0);

        // R2: word clock held high through reset, then low, data toggling
        tag_r = "R2";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wclk  = (i < 5);
            sdata = i[0] ^ i[2];
        end
        chk(nvalid == 0, "R2", "strobes before first frame", nvalid, 0);

        // R3 / R5: single-rate frames, padding high then patterned
        tag_r = "R3";
        send_frame(256, 1'b0, 3, 1'b1, -1, 0);
        tag_r = "R5";
        send_frame(256, 1'b0, 1, 1'b0, -1, 0);
        send_frame(256, 1'b0, 2, 1'b1, -1, 0);
        tag_r = "R3";
        send_frame(256, 1'b0, 4, 1'b0, -1, 0);
        chk(frame_err == 1'b0, "R11", "err after good single frames", frame_err, 0);

        // R6 / R10: dual-rate frames, one with the rate input toggled mid-frame
        tag_r = "R6";
        send_frame(128, 1'b1, 5, 1'b0, -1, 0);
        tag_r = "R10";
        send_frame(128, 1'b1, 6, 1'b1, 40, 0);
        tag_r = "R6";
        send_frame(128, 1'b1, 7, 1'b0, -1, 0);
        tag_r = "R11";
        send_frame(256, 1'b0, 8, 1'b0, -1, 0);
        chk(frame_err == 1'b0, "R10", "err after mid-frame rate toggle", frame_err, 0);
        chk(frame_err == 1'b0, "R11", "err across rate switch", frame_err, 0);

        // R7: short frame, then resynchronized frame
        tag_r = "R7";
        send_frame(100, 1'b0, 9, 1'b0, -1, 0);
        send_frame(256, 1'b0, 10, 1'b1, -1, 0);
        chk(frame_err == 1'b1, "R7", "err after early edge", frame_err, 1);

        // R9: flag survives good frames, reset clears it
        tag_r = "R9";
        send_frame(256, 1'b0, 11, 1'b0, -1, 0);
        send_frame(128, 1'b1, 12, 1'b0, -1, 0);
        chk(frame_err == 1'b1, "R9", "err held over good frames", frame_err, 1);
        @(negedge clk);
        wclk = 1'b0;
        rst  = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_err == 1'b0, "R9", "err cleared by reset", frame_err, 0);
        chk(smp_valid == 1'b0, "R1", "strobe after reset", smp_valid, 0);

        // R8: long frame, then resynchronized frame
        tag_r = "R8";
        send_frame(256, 1'b0, 13, 1'b0, -1, 0);
        send_frame(300, 1'b0, 14, 1'b1, -1, 256);
        send_frame(256, 1'b0, 15, 1'b0, -1, 0);
        chk(frame_err == 1'b1, "R8", "err after resync", frame_err, 1);

        @(negedge clk);
        wclk = 1'b0;
        repeat (8) @(negedge clk);
        chk(q.size() == 0, "R3", "final scoreboard", q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule